// File: doc/BRIEF.md
# Command-Byte Serial Register Port

This block is the slave end of a serial register link. The host selects the block with an active-low chip-select and clocks bits in on a serial data input. Each access starts with an 8-bit command byte. The top bit of that byte sets the direction. Bit 6 is reserved. The low six bits pick one of 64 register addresses. Exactly one data transfer follows the command byte. After it, the next bits are read as a new command byte.

The internal side is a simple register-file bus: an address, right-aligned write data, a one-cycle write strobe, a one-cycle read strobe, and a read-data input that the register file drives combinationally from the address. The address decides how long the data transfer is (8, 16 or 24 bits) and whether the address is mapped at all. Raising chip-select part way through a transaction abandons it without side effects.

The serial pins are brought into the system clock domain through a synchronizer and then edge-detected. Each serial half-period must therefore last at least four system clock cycles.

Top module: `cmd_serial_regport`

## Requirements
- R1: A transaction opens with an 8-bit command byte sent most significant bit first. The serial clock idles low, and `sdi` is sampled on each rising edge of `sclk` while `cs_n` is low.
- R2: Command bits 5:0 form the register address presented on `reg_addr`. Bit 6 has no effect on the transfer that follows.
- R3: With command bit 7 set, the data bits that follow are shifted in most significant bit first. After the last data bit, one `reg_wr` pulse carries the address and the data, right-aligned on `reg_wdata`, with unused upper bits zero.
- R4: With command bit 7 clear, one `reg_rd` pulse is issued right after the command byte, and `reg_rdata` is captured in full at that moment. The captured value is shifted out on `sdo` most significant bit first. `sdo` changes on falling edges of `sclk`, so each bit is valid before the rising edge that ends it. Later changes of `reg_rdata` do not alter the value being sent.
- R5: The data length depends on the address: 0x00–0x07 use 24 bits, 0x08–0x0F use 16 bits, 0x10–0x17 use 8 bits, and 0x18–0x3F use 8 bits.
- R6: Addresses 0x18–0x3F are unmapped. A write to one of them issues no `reg_wr`. A read from one of them issues no `reg_rd` and shifts out all zeros.
- R7: Once one data transfer completes, the next bits, even within the same chip-select window, are decoded as a fresh command byte.
- R8: Raising `cs_n` at any point aborts the transaction. No `reg_wr` is issued, and the next selection starts with a command byte.
- R9: After synchronous reset, `sdo`, `reg_wr` and `reg_rd` are low and the block waits for a command byte.
- R10: `sdo` is low while the block is deselected.
- R11: Every `reg_wr` pulse lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| reg_addr | output | 6 | Register address of current access |
| reg_wdata | output | 24 | Right-aligned write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 24 | Register read data, combinational from `reg_addr` |

## Verification
Writes and reads are sent to one address in each length band and to unmapped addresses. This separates the three transfer lengths and tells mapped from unmapped handling. Back-to-back transactions under a single chip-select show that the engine returns to command decoding. Aborts placed inside the command byte and inside a write's data phase show that nothing leaks into the register file and that decoding restarts cleanly. A read whose register is changed while it is being shifted out shows whether the value was captured whole at the end of the command byte. A command with the reserved bit set shows that the bit has no effect.

// File: rtl/regport_pkg.sv
// Package: shared widths and state encoding for the serial register port.
// Assumes a fixed 8-bit command byte with a 6-bit address field.
package regport_pkg;
    localparam int CMD_W   = 8;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 24;
    localparam int LEN_W   = $clog2(DATA_W + 1);
    localparam int CMD_DIR_BIT = 7;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_CAP  = 2'd1,
        ST_DATA = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/regport_sync.sv
// Module: regport_sync
// Brings chip-select, serial clock and serial data into the system clock
// domain through a STAGES-deep flop chain. It then flags the rising and
// falling edges of the serial clock.
// Assumes each serial half-period spans several system clock cycles.
module regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sclk_in,
    input  logic sdi_in,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s
);
    // bit 2 = cs_n, bit 1 = sclk, bit 0 = sdi
    logic [2:0] pipe [STAGES];
    logic       sclk_prev;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= 3'b100;
        else        pipe[0] <= {cs_n_in, sclk_in, sdi_in};
    end

    // Remaining stages of the chain.
    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[k] <= 3'b100;
                else        pipe[k] <= pipe[k-1];
            end
        end
    endgenerate

    // Previous synchronized serial clock, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= pipe[STAGES-1][1];
    end

    assign cs_act    = ~pipe[STAGES-1][2];
    assign sdi_s     = pipe[STAGES-1][0];
    assign sclk_rise = cs_act &  pipe[STAGES-1][1] & ~sclk_prev;
    assign sclk_fall = cs_act & ~pipe[STAGES-1][1] &  sclk_prev;
endmodule

// File: rtl/regport_lenmap.sv
// Module: regport_lenmap
// Decodes a register address into its data transfer length and a mapped flag.
// Addresses are grouped in banks of BANK_SIZE. Bank 0 is wide, bank 1 is
// medium and bank 2 is narrow. Every higher address is unmapped and uses
// the narrow length.
module regport_lenmap
    import regport_pkg::*;
#(
    parameter int BANK_SIZE = 8,
    parameter int LEN_WIDE  = 24,
    parameter int LEN_MID   = 16,
    parameter int LEN_NARROW = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  len_bits,
    output logic              mapped
);
    localparam int BANK_SH = $clog2(BANK_SIZE);
    localparam int BANK_W  = ADDR_W - BANK_SH;

    logic [BANK_W-1:0] bank;
    assign bank = addr[ADDR_W-1:BANK_SH];

    // Select the length from the bank number.
    always_comb begin
        mapped = 1'b1;
        case (bank)
            BANK_W'(0): len_bits = LEN_W'(LEN_WIDE);
            BANK_W'(1): len_bits = LEN_W'(LEN_MID);
            BANK_W'(2): len_bits = LEN_W'(LEN_NARROW);
            default: begin
                len_bits = LEN_W'(LEN_NARROW);
                mapped   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/regport_core.sv
// Module: regport_core
// Transfer engine: collects the command byte, captures read data, shifts data
// in or out, and issues the register strobes.
// Assumes synchronized inputs with one-cycle edge flags and no serial edge
// during the single capture cycle.
module regport_core
    import regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic [LEN_W-1:0]  len_bits,
    input  logic              mapped,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              wr,
    output logic              rd,
    output logic              sdo
);
    xfer_state_e        state;
    logic [LEN_W-1:0]   bitcnt;
    logic [DATA_W-1:0]  rx;
    logic [DATA_W-1:0]  rx_next;
    logic [DATA_W-1:0]  tx;
    logic [CMD_W-1:0]   cmd_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               wr_q;
    logic               sdo_q;
    logic [DATA_W:0]    one_sh;
    logic [DATA_W-1:0]  len_mask;
    logic [DATA_W-1:0]  rd_aligned;
    logic               is_write;

    assign is_write   = cmd_q[CMD_DIR_BIT];
    assign rx_next    = {rx[DATA_W-2:0], sdi_s};
    assign one_sh     = (DATA_W+1)'(1) << len_bits;
    assign len_mask   = DATA_W'(one_sh - 1'b1);
    assign rd_aligned = rdata << (LEN_W'(DATA_W) - len_bits);

    // Main sequencer: command phase, capture cycle, data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CMD;
            bitcnt  <= '0;
            rx      <= '0;
            tx      <= '0;
            cmd_q   <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            sdo_q   <= 1'b0;
        end else if (!cs_act) begin
            state  <= ST_CMD;
            bitcnt <= '0;
            tx     <= '0;
            wr_q   <= 1'b0;
            sdo_q  <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            case (state)
                ST_CMD: begin
                    if (sclk_fall) sdo_q <= 1'b0;
                    if (sclk_rise) begin
                        rx <= rx_next;
                        if (bitcnt == LEN_W'(CMD_W - 1)) begin
                            cmd_q  <= rx_next[CMD_W-1:0];
                            bitcnt <= '0;
                            state  <= ST_CAP;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_CAP: begin
                    tx    <= (!is_write && mapped) ? rd_aligned : '0;
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    if (sclk_fall && !is_write) begin
                        sdo_q <= tx[DATA_W-1];
                        tx    <= {tx[DATA_W-2:0], 1'b0};
                    end
                    if (sclk_rise) begin
                        rx <= rx_next;
                        if (bitcnt == len_bits - 1'b1) begin
                            bitcnt <= '0;
                            state  <= ST_CMD;
                            if (is_write && mapped) begin
                                wr_q    <= 1'b1;
                                wdata_q <= rx_next & len_mask;
                            end
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_CMD;
            endcase
        end
    end

    assign addr  = cmd_q[ADDR_W-1:0];
    assign wdata = wdata_q;
    assign wr    = wr_q;
    assign rd    = (state == ST_CAP) && !is_write && mapped;
    assign sdo   = sdo_q;

    // R11: a write strobe never stretches past one cycle
    assert_wr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |=> !wr_q);
    // R8: deselection leaves no write strobe behind
    assert_no_wr_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !wr_q);
    // R4: a read strobe is followed by the data phase
    assert_rd_to_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (state == ST_DATA || !cs_act));
    // R10: output is quiet after deselection
    assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo_q);
    // R5: bit counter stays inside the decoded length
    assert_bitcnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bitcnt < len_bits));
    // R6: no write strobe reaches an unmapped address
    assert_unmapped_no_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> mapped);
    // R7: leaving the data phase restarts the command count
    assert_cmd_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DATA && state == ST_CMD) |-> (bitcnt == '0));
endmodule

// File: rtl/cmd_serial_regport.sv
// Module: cmd_serial_regport
// Top level of the serial register port: synchronizer, length decoder and
// transfer engine. The register file must return read data combinationally
// from reg_addr.
module cmd_serial_regport
    import regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic             cs_act;
    logic             sclk_rise;
    logic             sclk_fall;
    logic             sdi_s;
    logic [LEN_W-1:0] len_bits;
    logic             mapped;
    logic [ADDR_W-1:0] addr_w;

    regport_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_in   (cs_n),
        .sclk_in   (sclk),
        .sdi_in    (sdi),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s)
    );

    regport_lenmap lenmap_i (
        .addr     (addr_w),
        .len_bits (len_bits),
        .mapped   (mapped)
    );

    regport_core core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s),
        .len_bits  (len_bits),
        .mapped    (mapped),
        .rdata     (reg_rdata),
        .addr      (addr_w),
        .wdata     (reg_wdata),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .sdo       (sdo)
    );

    assign reg_addr = addr_w;
endmodule

// File: tb/cmd_serial_regport_tb_top.sv
// Bench: drives serial transactions, keeps a behavioural model of the register
// contents and strobe counts, and compares on every clock and per transaction.
module cmd_serial_regport_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [5:0]  reg_addr;
    logic [23:0] reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [23:0] reg_rdata;

    logic [23:0] regs [64];
    logic [23:0] mdl  [64];
    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int exp_wr = 0;
    int exp_rd = 0;
    logic [5:0]  last_addr;
    logic [23:0] last_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_serial_regport dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];

    // Register file and strobe monitor, every clock.
    always @(posedge clk) begin
        if (reg_wr) begin
            regs[reg_addr] <= reg_wdata;
            wr_cnt    <= wr_cnt + 1;
            last_addr <= reg_addr;
            last_data <= reg_wdata;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [5:0] a);
        if (a < 8) return 24;
        if (a < 16) return 16;
        return 8;
    endfunction

    function automatic logic [23:0] mask_of(input int n);
        return (n >= 24) ? 24'hFFFFFF : 24'((1 << n) - 1);
    endfunction

    task automatic sel();
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Shift n bits of val out MSB first, sampling sdo before each rising edge.
    task automatic shift_bits(input logic [23:0] val, input int n, output logic [23:0] got);
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) sdi = val[i];
            repeat (HALF - 1) @(negedge clk);
            got[i] = sdo;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    // One full transaction inside an open selection, with model update and checks.
    task automatic xact(input logic [7:0] cmd, input logic [23:0] wval, input string req);
        logic [5:0]  a;
        int          n;
        bit          mp;
        logic [23:0] got;
        logic [23:0] exp;
        a  = cmd[5:0];
        n  = len_of(a);
        mp = (a < 24);
        shift_bits({16'h0, cmd}, 8, got);
        if (cmd[7]) begin
            shift_bits(wval, n, got);
            repeat (5) @(negedge clk);
            if (mp) begin
                exp_wr++;
                mdl[a] = wval & mask_of(n);
            end
            chk(wr_cnt == exp_wr, {req, " write strobe count"}, 24'(wr_cnt), 24'(exp_wr));
            if (mp) begin
                chk(last_addr == a, {req, " write address"}, {18'h0, last_addr}, {18'h0, a});
                chk(last_data == mdl[a], {req, " write data"}, last_data, mdl[a]);
            end
        end else begin
            exp = mp ? (mdl[a] & mask_of(n)) : 24'h0;
            if (mp) exp_rd++;
            shift_bits(24'h0, n, got);
            repeat (5) @(negedge clk);
            chk(got == exp, {req, " read data"}, got, exp);
            chk(rd_cnt == exp_rd, {req, " read strobe count"}, 24'(rd_cnt), 24'(exp_rd));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] g1;
        logic [23:0] g2;
        logic [23:0] old;
        for (int i = 0; i < 64; i++) begin
            regs[i] = 24'h5A0000 ^ 24'(i * 24'h010203) ^ 24'h00A5C3;
            mdl[i]  = regs[i];
        end
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(sdo == 1'b0, "R9 sdo in reset", {23'h0, sdo}, 24'h0);
        chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R9 strobes in reset", {22'h0, reg_wr, reg_rd}, 24'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 R3 R5: writes in each length band
        sel(); xact(8'h83, 24'hC3A5F1, "R3 R5 wide write"); desel();
        sel(); xact(8'h8A, 24'h12BEEF, "R3 R5 mid write"); desel();
        sel(); xact(8'h95, 24'hFFFF7E, "R3 R5 narrow write"); desel();
        // R4 R5: reads back in each band
        sel(); xact(8'h03, 24'h0, "R4 R5 wide read"); desel();
        sel(); xact(8'h0A, 24'h0, "R4 R5 mid read"); desel();
        sel(); xact(8'h15, 24'h0, "R4 R5 narrow read"); desel();
        sel(); xact(8'h00, 24'h0, "R1 R4 untouched read"); desel();
        // R10: sdo low after deselection
        chk(sdo == 1'b0, "R10 sdo deselected", {23'h0, sdo}, 24'h0);
        // R2: reserved bit 6 set has no effect
        sel(); xact(8'hC9, 24'h00ABCD, "R2 write bit6 set"); desel();
        sel(); xact(8'h49, 24'h0, "R2 read bit6 set"); desel();
        // R6: unmapped write and read
        sel(); xact(8'hA0, 24'h0000FF, "R6 unmapped write"); desel();
        sel(); xact(8'h3F, 24'h0, "R6 unmapped read"); desel();
        sel(); xact(8'h18, 24'h0, "R6 unmapped read low edge"); desel();
        // R7: back-to-back transactions under one selection
        sel();
        xact(8'h81, 24'h0F1E2D, "R7 first write");
        xact(8'h01, 24'h0, "R7 readback same select");
        xact(8'h8F, 24'h00B00C, "R7 third write");
        xact(8'h0F, 24'h0, "R7 fourth read");
        desel();
        // R8: abort inside data phase of a write
        sel();
        shift_bits(24'h000084, 8, g1);
        shift_bits(24'hFFFFFF, 10, g1);
        desel();
        chk(wr_cnt == exp_wr, "R8 no write after abort", 24'(wr_cnt), 24'(exp_wr));
        sel(); xact(8'h04, 24'h0, "R8 register intact after abort"); desel();
        // R8: abort inside command byte, next selection decodes fresh
        sel();
        shift_bits(24'h000015, 5, g1);
        desel();
        sel(); xact(8'h92, 24'h000033, "R8 write after cmd abort"); desel();
        sel(); xact(8'h12, 24'h0, "R8 read after cmd abort"); desel();
        // R4: capture coherence, register changes mid-shift
        sel();
        shift_bits(24'h000006, 8, g1);
        old = mdl[6];
        shift_bits(24'h0, 4, g1);
        regs[6] = ~regs[6];
        mdl[6]  = regs[6];
        shift_bits(24'h0, 20, g2);
        exp_rd++;
        repeat (5) @(negedge clk);
        chk(((g1 & 24'hF) << 20 | g2) == old, "R4 coherent capture", (g1 & 24'hF) << 20 | g2, old);
        chk(rd_cnt == exp_rd, "R4 read strobe count coherent", 24'(rd_cnt), 24'(exp_rd));
        desel();
        // R3 R6 R11: register file matches model, one strobe per write
        for (int i = 0; i < 64; i++)
            chk(regs[i] == mdl[i], (i < 24) ? "R3 R11 final contents" : "R6 unmapped untouched", regs[i], mdl[i]);
        chk(wr_cnt == exp_wr, "R11 total write strobes", 24'(wr_cnt), 24'(exp_wr));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule